// File: doc/BRIEF.md
# Write-masked half-word control register bank

This block holds a small set of 32-bit control registers for a chip's configuration space. Only the low 16 bits of each register carry state. On a write, the high 16 bits of the bus word are not data. They form a per-bit enable: low bit `i` is loaded only when bit `i+16` of the write word is set. Software can therefore change one field in a single write, without reading the register first and without disturbing its other fields.

A field of width `w` at bit offset `s` is updated by writing `(value << s) | (((1<<w)-1) << (s+16))`. One field layout packs four 4-bit per-lane fields at offsets 0, 4, 8 and 12. Another mixes an 8-bit field with single-bit flags in the same register.

One extra address returns an external 8-bit status value and cannot be written. Reads are combinational on the address. Control registers read back as their low half, with zeros above. Every register's contents also drive a flat output bus for the logic being configured.

Top module: `masked_ctrl_bank`

## Requirements
- R1: On a write to control register k (word address k, 0 <= k < NUM_REGS), each low bit i whose enable bit i+16 of `wr_data` is 1 takes the value of `wr_data[i]`, at the clock edge where `wr_en` is high.
- R2: On such a write, each low bit whose enable bit is 0 keeps its previous value, whatever `wr_data[i]` holds. A write whose enable half is all zero changes nothing.
- R3: While `rst_n` is low at a clock edge, every stored bit becomes 0. This holds both at power-up and for a reset in the middle of operation.
- R4: Reading control register k returns the stored 16 bits in `rd_data[15:0]`, and `rd_data[31:16]` is always 0.
- R5: Reading address STATUS_ADDR (default 8) returns `stat_in` in `rd_data[7:0]`, with bits 31:8 equal to 0.
- R6: A write to STATUS_ADDR, or to any address that is neither a control register nor STATUS_ADDR, changes no stored bit. Reading an unmapped address returns 0.
- R7: `ctrl_out[16k+15:16k]` always equals the stored contents of control register k.
- R8: The four 4-bit fields at offsets 0, 4, 8 and 12 of one register can each be written alone, and each such write leaves the other three fields intact.
- R9: An 8-bit field at offset 3 and single-bit flags at offsets 0 and 11 of one register can be set and cleared independently of one another.
- R10: A written value appears on `rd_data` and `ctrl_out` in the cycle after the write edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W (4) | Word address for both read and write |
| wr_data | input | 32 | Bits 31:16 are the bit enable, bits 15:0 are the new value |
| stat_in | input | STAT_W (8) | External status value, read at STATUS_ADDR |
| rd_data | output | 32 | Combinational read data for `addr` |
| ctrl_out | output | NUM_REGS*16 (64) | Contents of every control register, register k at bits 16k+15:16k |

## Verification
The bench writes fields whose value bits fall outside their enable mask. A design that loaded the whole low half, or used the enable bits as data, would then corrupt neighbouring lane fields or flags. It writes with an all-zero enable half and writes all ones to the status and unmapped addresses. Any decode that leaks across addresses would then change `ctrl_out`. It also checks that the high read half stays zero after all-ones writes, that a read in the cycle of a write still shows the old value, and that a mid-run reset clears every register.

// File: rtl/mcb_pkg.sv
// Package: shared widths and the masked-merge function for the
// write-masked control register bank.
// Assumes a 32-bit bus word split into an enable half and a value half.
package mcb_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    // Merge new value bits into old state under a per-bit enable.
    function automatic logic [HALF_W-1:0] merge_masked(
        input logic [HALF_W-1:0] old_q,
        input logic [HALF_W-1:0] val,
        input logic [HALF_W-1:0] en
    );
        return (old_q & ~en) | (val & en);
    endfunction
endpackage

// File: rtl/mcb_decode.sv
// Module: write decoder. Turns a bus write into at most one register
// select. Assumes control registers sit at word addresses 0..NUM_REGS-1
// and that every other address, the status address included, is not
// writable.
module mcb_decode #(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel
);
    // One comparator per register: select it on a write to its address.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
        assign sel[k] = wr_en && (addr == ADDR_W'(k));
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R6

    AST_NO_WRITE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (sel == '0)); // R6
endmodule

// File: rtl/mcb_cell.sv
// Module: one 16-bit control register with per-bit write enable.
// Assumes the decoder raises sel for at most one cell per cycle.
// Reset is synchronous and active low.
module mcb_cell
    import mcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [HALF_W-1:0] val,
    input  logic [HALF_W-1:0] en,
    output logic [HALF_W-1:0] q
);
    // State update: clear on reset, otherwise load only the enabled bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (sel) begin
            q <= merge_masked(q, val, en);
        end
    end

    AST_ENABLED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> (((q ^ $past(val)) & $past(en)) == '0)); // R1

    AST_DISABLED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> (((q ^ $past(q)) & ~$past(en)) == '0)); // R2

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(q)); // R6
endmodule

// File: rtl/mcb_rdmux.sv
// Module: combinational read path. Returns the low half of a control
// register with a zero upper half, the zero-extended status value at
// STATUS_ADDR, and zero for every other address.
// Assumes STATUS_ADDR >= NUM_REGS.
module mcb_rdmux
    import mcb_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int ADDR_W      = 4,
    parameter int STAT_W      = 8,
    parameter int STATUS_ADDR = 8
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_REGS*HALF_W-1:0] regs_flat,
    input  logic [STAT_W-1:0]        stat_in,
    output logic [WORD_W-1:0]        rd_data
);
    // Address match: pick the addressed register or the status value.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (addr == ADDR_W'(k)) begin
                rd_data = {{HALF_W{1'b0}}, regs_flat[k*HALF_W +: HALF_W]};
            end
        end
        if (addr == ADDR_W'(STATUS_ADDR)) begin
            rd_data = WORD_W'(stat_in);
        end
    end
endmodule

// File: rtl/masked_ctrl_bank.sv
// Module: top of the write-masked control register bank.
// On a write, wr_data[31:16] enables individual bits of wr_data[15:0].
// Assumes a single-cycle write strobe and combinational reads.
// Reset is synchronous and active low.
module masked_ctrl_bank
    import mcb_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int ADDR_W      = 4,
    parameter int STAT_W      = 8,
    parameter int STATUS_ADDR = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic [STAT_W-1:0]          stat_in,
    output logic [WORD_W-1:0]          rd_data,
    output logic [NUM_REGS*HALF_W-1:0] ctrl_out
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    logic [NUM_REGS-1:0] sel;
    logic [HALF_W-1:0]   wr_val;
    logic [HALF_W-1:0]   wr_en_bits;

    // Bus word split: low half is the value, high half the bit enable.
    assign wr_val     = wr_data[HALF_W-1:0];
    assign wr_en_bits = wr_data[WORD_W-1:HALF_W];

    mcb_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .sel   (sel)
    );

    // One masked register per control address.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_cell
        mcb_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel[k]),
            .val   (wr_val),
            .en    (wr_en_bits),
            .q     (ctrl_out[k*HALF_W +: HALF_W])
        );
    end

    mcb_rdmux #(
        .NUM_REGS    (NUM_REGS),
        .ADDR_W      (ADDR_W),
        .STAT_W      (STAT_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_rd (
        .addr      (addr),
        .regs_flat (ctrl_out),
        .stat_in   (stat_in),
        .rd_data   (rd_data)
    );

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < ADDR_W'(NUM_REGS)) |-> (rd_data[WORD_W-1:HALF_W] == '0)); // R4

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == STAT_A) |-> (rd_data == WORD_W'(stat_in))); // R5

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr >= ADDR_W'(NUM_REGS)) && (addr != STAT_A)) |-> (rd_data == '0)); // R6

    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (addr >= ADDR_W'(NUM_REGS))) |=> $stable(ctrl_out)); // R6
endmodule

// File: tb/masked_ctrl_bank_test.sv
// Bench for masked_ctrl_bank: a vector table of writes and read-backs,
// followed by directed tests of reset, status, unmapped addresses and timing.
module masked_ctrl_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  stat_in = '0;
    logic [31:0] rd_data;
    logic [63:0] ctrl_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    masked_ctrl_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .stat_in(stat_in), .rd_data(rd_data),
        .ctrl_out(ctrl_out)
    );

    // Each row: {addr[3:0], wr_data[31:0], expected read-back[31:0]}
    localparam logic [67:0] VEC [13] = '{
        {4'd0, 32'h000F_0005, 32'h0000_0005},  // R8 lane 0
        {4'd0, 32'h00F0_00A0, 32'h0000_00A5},  // R8 lane 1
        {4'd0, 32'h0F00_0C00, 32'h0000_0CA5},  // R8 lane 2
        {4'd0, 32'hF000_3000, 32'h0000_3CA5},  // R8 lane 3
        {4'd0, 32'h00F0_FF0F, 32'h0000_3C05},  // R2 out-of-mask value ignored
        {4'd0, 32'h0000_FFFF, 32'h0000_3C05},  // R2 empty enable
        {4'd1, 32'h07F8_05B8, 32'h0000_05B8},  // R9 8-bit field at offset 3
        {4'd1, 32'h0801_0801, 32'h0000_0DB9},  // R9 flags at 0 and 11
        {4'd1, 32'h07F8_0000, 32'h0000_0801},  // R9 clear field, flags kept
        {4'd2, 32'hFFFF_1234, 32'h0000_1234},  // R1 full write
        {4'd3, 32'hFFFF_FFFF, 32'h0000_FFFF},  // R4 upper half reads zero
        {4'd3, 32'h8000_0000, 32'h0000_7FFF},  // R1 clear single bit
        {4'd2, 32'h00FF_ABCD, 32'h0000_12CD}   // R1 low byte only
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic read_at(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R3 reset state
        check("R3 ctrl_out after reset", ctrl_out, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            read_at(4'(k), r);
            check("R3 read after reset", r, 32'h0);
        end

        // Vector table
        for (int i = 0; i < 13; i++) begin
            do_write(VEC[i][67:64], VEC[i][63:32]);
            read_at(VEC[i][67:64], r);
            check("R1/R2 vector read-back", r, VEC[i][31:0]);
        end
        check("R7 ctrl_out map", ctrl_out, 64'h7FFF_12CD_0801_3C05);

        // R5 status read
        stat_in = 8'hA5;
        read_at(4'd8, r);
        check("R5 status read", r, 32'h0000_00A5);

        // R6 status and unmapped writes ignored
        do_write(4'd8, 32'hFFFF_FFFF);
        check("R6 status write ignored", ctrl_out, 64'h7FFF_12CD_0801_3C05);
        read_at(4'd8, r);
        check("R6 status still input", r, 32'h0000_00A5);
        do_write(4'd5, 32'hFFFF_FFFF);
        do_write(4'd15, 32'hFFFF_0000);
        check("R6 unmapped write ignored", ctrl_out, 64'h7FFF_12CD_0801_3C05);
        read_at(4'd5, r);
        check("R6 unmapped read zero", r, 32'h0);

        // R10 write visible only after the edge
        @(negedge clk);
        addr = 4'd2; wr_data = 32'hFFFF_5555; wr_en = 1'b1;
        #1;
        check("R10 old value before edge", rd_data, 32'h0000_12CD);
        @(posedge clk);
        #1;
        check("R10 new value after edge", rd_data, 32'h0000_5555);
        check("R10 ctrl_out after edge", ctrl_out, 64'h7FFF_5555_0801_3C05);
        @(negedge clk);
        wr_en = 1'b0;

        // R3 mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R3 mid-run reset", ctrl_out, 64'h0);
        read_at(4'd3, r);
        check("R3 read after mid-run reset", r, 32'h0);

        finish_run();
    end
endmodule